// File: doc/BRIEF.md
# Multiplexed Sample History Recorder

The recorder shares one 10-bit converter among four supply channels. Each channel is sampled twice per round, once for its output voltage and once for its load current, which gives eight measurement slots. A free-running slot timer sets the round cadence. At the start of each slot the block points the analog mux at the slot's signal and starts a conversion, provided the converter has finished its previous job. The converter appears as a start/done handshake. When a result arrives, it is stored in a latest-value register for that signal and appended to that signal's own ring of the 50 most recent samples.

When a fault is detected, the fault logic raises a freeze request. From the following cycle the rings stop taking samples, so the lead-up to the fault stays intact for the host to read. The latest-value registers keep tracking the live readings. A host clear resumes recording. The host reads any ring at any time by giving a signal number and an offset back from the newest sample.

With the default 200 MHz clock and 2500 cycles per slot, one round lasts 100 µs and each ring holds 5 ms of history.

Top module: `sample_history_recorder`

## Requirements
- R1: The mux select steps through signal codes 0 to 7 in the order ch1 voltage, ch1 current, ch2 voltage, ch2 current, up to ch4 current. The code for channel c (numbered from 0) is 2c for voltage and 2c+1 for current. The select advances by one, wrapping 7 to 0, every SLOT_CYCLES clocks and holds steady in between.
- R2: A slot's conversion-start is a single-cycle pulse. It is raised in the second cycle of the slot and only when no conversion is outstanding, so at most one conversion is ever in flight.
- R3: If a conversion is still outstanding when a slot begins, that slot issues no start. The slot timing and the select sequence are unaffected.
- R4: A done strobe that arrives while a conversion is outstanding writes its data into the latest-value register of the signal that was started, visible one cycle later. A done strobe with no conversion outstanding changes nothing.
- R5: Each signal has its own write pointer, running from 0 to 49 and then wrapping to 0. Once more than 50 samples have arrived, the oldest are overwritten.
- R6: The read data is registered and appears one cycle after the read address. Offset 0 returns the newest stored sample of the selected signal and offset k returns the sample k writes earlier. An offset of 50 or more, or a position never written since reset, reads as 0.
- R7: A freeze request stops all ring writes and pointer movement from the next cycle on. The latest-value registers keep updating.
- R8: A host clear releases the freeze. When a freeze request and a clear arrive in the same cycle, the freeze request wins.
- R9: Reset clears every ring entry, pointer, latest value and the read data. It sets the select to code 0 with no start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adc_done | input | 1 | Converter result-valid strobe |
| adc_data | input | 10 | Converter result |
| conv_start | output | 1 | Conversion-start pulse |
| mux_sel | output | 3 | Analog mux signal code |
| freeze_req | input | 1 | Fault freeze request |
| freeze_clr | input | 1 | Host release of the freeze |
| rd_sig | input | 3 | Host read: signal code |
| rd_back | input | 6 | Host read: offset back from newest |
| rd_data | output | 10 | Host read data (one-cycle latency) |
| latest_flat | output | 80 | Latest values, signal s in bits [10s+9:10s] |

## Verification
A behavioural model runs alongside the design. It keeps one queue per signal and compares the mux, the start pulse, every latest value and the read data on every clock, while random read addresses sweep all signals and offsets up to 63.

The run drives each ring well past 50 samples. A wrong pointer wrap would return stale or shifted history at offsets near 49, and missing range handling would return garbage at offsets of 50 or more.

Converter latency is then made longer than a slot. A design that started regardless would pulse while busy or store a result under the wrong signal.

Spurious done strobes, a freeze, a release, and a freeze coinciding with a release complete the run. These catch rings that keep moving while frozen, frozen latest values, and the wrong priority between the two host controls.

// File: rtl/shr_pkg.sv
package shr_pkg;

  // Next write position in a ring of the given depth.
  function automatic int unsigned ring_next(int unsigned pos, int unsigned depth);
    return (pos == depth - 1) ? 0 : pos + 1;
  endfunction

  // Position holding the sample 'back' writes before the newest one,
  // given the next write position. Caller keeps back < depth.
  function automatic int unsigned ring_back(int unsigned wpos, int unsigned back,
                                            int unsigned depth);
    int unsigned t;
    t = wpos + depth - 1 - back;
    return (t >= depth) ? t - depth : t;
  endfunction

  // Next slot code, wrapping after the last signal.
  function automatic int unsigned slot_next(int unsigned sel, int unsigned sigs);
    return (sel == sigs - 1) ? 0 : sel + 1;
  endfunction

endpackage

// File: rtl/shr_slot_seq.sv
module shr_slot_seq
  import shr_pkg::*;
#(
  parameter int unsigned SIGS        = 8,
  parameter int unsigned SLOT_CYCLES = 2500,
  parameter int unsigned SELW        = $clog2(SIGS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            adc_done,
  output logic [SELW-1:0] slot_sel,
  output logic            conv_start,
  output logic            accept,
  output logic            slot_end,
  output logic [SELW-1:0] pend_sig
);
  localparam int unsigned CW = (SLOT_CYCLES > 2) ? $clog2(SLOT_CYCLES) : 1;

  logic [CW-1:0] cnt_q;
  logic          busy_q;
  logic          launch;

  assign slot_end = (cnt_q == CW'(SLOT_CYCLES - 1));
  assign launch   = (cnt_q == '0) && !busy_q;
  assign accept   = adc_done && busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      slot_sel   <= '0;
      busy_q     <= 1'b0;
      conv_start <= 1'b0;
      pend_sig   <= '0;
    end else begin
      cnt_q      <= slot_end ? '0 : cnt_q + 1'b1;
      if (slot_end)
        slot_sel <= SELW'(slot_next(int'(slot_sel), SIGS));
      conv_start <= launch;
      if (launch) begin
        busy_q   <= 1'b1;
        pend_sig <= slot_sel;
      end else if (accept) begin
        busy_q   <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/shr_freeze_ctl.sv
module shr_freeze_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic freeze_req,
  input  logic freeze_clr,
  output logic frozen
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          frozen <= 1'b0;
    else if (freeze_req) frozen <= 1'b1;
    else if (freeze_clr) frozen <= 1'b0;
  end
endmodule

// File: rtl/shr_lane.sv
module shr_lane
  import shr_pkg::*;
#(
  parameter int unsigned DW    = 10,
  parameter int unsigned DEPTH = 50,
  parameter int unsigned PW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap,
  input  logic          hist_we,
  input  logic [DW-1:0] din,
  input  logic [PW-1:0] back,
  output logic [DW-1:0] rd_word,
  output logic [DW-1:0] latest,
  output logic [PW-1:0] wptr
);
  logic [DW-1:0] ring [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) ring[i] <= '0;
      wptr   <= '0;
      latest <= '0;
    end else begin
      if (cap) latest <= din;
      if (hist_we) begin
        ring[wptr] <= din;
        wptr       <= PW'(ring_next(int'(wptr), DEPTH));
      end
    end
  end

  always_comb begin
    if (int'(back) >= DEPTH) rd_word = '0;
    else rd_word = ring[PW'(ring_back(int'(wptr), int'(back), DEPTH))];
  end

endmodule

// File: rtl/sample_history_recorder.sv
module sample_history_recorder #(
  parameter int unsigned CHANNELS    = 4,
  parameter int unsigned DW          = 10,
  parameter int unsigned DEPTH       = 50,
  parameter int unsigned SLOT_CYCLES = 2500
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         adc_done,
  input  logic [DW-1:0]                adc_data,
  output logic                         conv_start,
  output logic [$clog2(2*CHANNELS)-1:0] mux_sel,
  input  logic                         freeze_req,
  input  logic                         freeze_clr,
  input  logic [$clog2(2*CHANNELS)-1:0] rd_sig,
  input  logic [$clog2(DEPTH)-1:0]     rd_back,
  output logic [DW-1:0]                rd_data,
  output logic [2*CHANNELS*DW-1:0]     latest_flat
);
  localparam int unsigned SIGS = 2 * CHANNELS;
  localparam int unsigned SELW = $clog2(SIGS);
  localparam int unsigned PW   = $clog2(DEPTH);

  // Named internal events, brought out for the checker.
  logic            accept_w;
  logic            slot_end_w;
  logic [SELW-1:0] pend_sig_q;
  logic            frozen_q;
  logic [SIGS*PW-1:0] wptr_bus;
  logic [DW-1:0]   lane_rd [SIGS];

  shr_slot_seq #(
    .SIGS(SIGS), .SLOT_CYCLES(SLOT_CYCLES), .SELW(SELW)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .adc_done(adc_done),
    .slot_sel(mux_sel), .conv_start(conv_start), .accept(accept_w),
    .slot_end(slot_end_w), .pend_sig(pend_sig_q)
  );

  shr_freeze_ctl u_frz (
    .clk(clk), .rst_n(rst_n), .freeze_req(freeze_req),
    .freeze_clr(freeze_clr), .frozen(frozen_q)
  );

  for (genvar s = 0; s < SIGS; s++) begin : g_lane
    logic cap_s;
    assign cap_s = accept_w && (pend_sig_q == SELW'(s));
    shr_lane #(.DW(DW), .DEPTH(DEPTH), .PW(PW)) u_lane (
      .clk(clk), .rst_n(rst_n), .cap(cap_s), .hist_we(cap_s && !frozen_q),
      .din(adc_data), .back(rd_back), .rd_word(lane_rd[s]),
      .latest(latest_flat[s*DW +: DW]), .wptr(wptr_bus[s*PW +: PW])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= '0;
    else        rd_data <= lane_rd[rd_sig];
  end

endmodule

// File: rtl/shr_checker.sv
module shr_checker #(
  parameter int unsigned SIGS  = 8,
  parameter int unsigned DW    = 10,
  parameter int unsigned DEPTH = 50,
  parameter int unsigned PW    = 6,
  parameter int unsigned SELW  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              conv_start,
  input logic              adc_done,
  input logic              accept,
  input logic              slot_end,
  input logic              frozen,
  input logic              freeze_req,
  input logic [SELW-1:0]   mux_sel,
  input logic [SELW-1:0]   pend_sig,
  input logic [DW-1:0]     adc_data,
  input logic [SIGS*DW-1:0] latest_flat,
  input logic [SIGS*PW-1:0] wptr_bus
);
  // R1
  sel_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_end |=> mux_sel == (($past(mux_sel) == SELW'(SIGS-1)) ? '0 : SELW'($past(mux_sel) + 1'b1)));
  // R1
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_end |=> $stable(mux_sel));
  // R2
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);
  // R2
  no_start_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !conv_start);
  // R4
  latest_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> latest_flat[$past(pend_sig)*DW +: DW] == $past(adc_data));
  // R7
  frozen_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frozen |=> $stable(wptr_bus));
  // R8
  freeze_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    freeze_req |=> frozen);
  for (genvar s = 0; s < SIGS; s++) begin : g_ptr
    // R5
    ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int'(wptr_bus[s*PW +: PW]) < DEPTH);
  end
endmodule

bind sample_history_recorder shr_checker #(
  .SIGS(SIGS), .DW(DW), .DEPTH(DEPTH), .PW(PW), .SELW(SELW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .adc_done(adc_done),
  .accept(accept_w), .slot_end(slot_end_w), .frozen(frozen_q),
  .freeze_req(freeze_req), .mux_sel(mux_sel), .pend_sig(pend_sig_q),
  .adc_data(adc_data), .latest_flat(latest_flat), .wptr_bus(wptr_bus)
);

// File: tb/sample_history_recorder_test.sv
`timescale 1ns/1ps
module sample_history_recorder_test;
  localparam int SLOT = 8;
  localparam int NS   = 8;
  localparam int DEP  = 50;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic adc_done, freeze_req, freeze_clr, conv_start;
  logic [9:0] adc_data, rd_data;
  logic [2:0] mux_sel, rd_sig;
  logic [5:0] rd_back;
  logic [79:0] latest_flat;

  always #2.5 clk = ~clk;

  sample_history_recorder #(.SLOT_CYCLES(SLOT)) uut (
    .clk(clk), .rst_n(rst_n), .adc_done(adc_done), .adc_data(adc_data),
    .conv_start(conv_start), .mux_sel(mux_sel), .freeze_req(freeze_req),
    .freeze_clr(freeze_clr), .rd_sig(rd_sig), .rd_back(rd_back),
    .rd_data(rd_data), .latest_flat(latest_flat)
  );

  int vectors = 0, misses = 0;
  string cs_tag = "R9", rd_tag = "R9", lt_tag = "R9", sel_tag = "R9";

  task automatic chk(string req, string what, int act, int exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Reference model: queues per signal, integer state.
  int m_cnt = 0, m_sel = 0, m_busy = 0, m_pend = 0, m_frozen = 0, m_cs = 0, m_rd = 0;
  int m_latest [NS];
  int hist [NS][$];
  int launch_i, accept_i, sz_i, k_i;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_sel = 0; m_busy = 0; m_pend = 0; m_frozen = 0; m_cs = 0; m_rd = 0;
      for (int s = 0; s < NS; s++) begin m_latest[s] = 0; hist[s].delete(); end
    end else begin
      launch_i = (m_cnt == 0 && m_busy == 0) ? 1 : 0;
      accept_i = (adc_done && m_busy == 1) ? 1 : 0;
      k_i  = int'(rd_back);
      sz_i = hist[rd_sig].size();
      m_rd = (k_i < DEP && k_i < sz_i) ? hist[rd_sig][sz_i-1-k_i] : 0;
      if (accept_i == 1) begin
        m_latest[m_pend] = int'(adc_data);
        if (m_frozen == 0) begin
          hist[m_pend].push_back(int'(adc_data));
          if (hist[m_pend].size() > DEP) void'(hist[m_pend].pop_front());
        end
      end
      if (freeze_req) m_frozen = 1;
      else if (freeze_clr) m_frozen = 0;
      m_cs = launch_i;
      if (launch_i == 1) begin m_busy = 1; m_pend = m_sel; end
      else if (accept_i == 1) m_busy = 0;
      if (m_cnt == SLOT-1) begin m_cnt = 0; m_sel = (m_sel + 1) % NS; end
      else m_cnt++;
    end
  end

  // Compare on every clock, away from the active edge.
  bit cmp_en = 0;
  initial begin
    @(negedge clk);
    cmp_en = 1;
    forever begin
      @(negedge clk);
      chk(cs_tag, "conv_start", int'(conv_start), m_cs);
      chk(sel_tag, "mux_sel", int'(mux_sel), m_sel);
      chk(rd_tag, "rd_data", int'(rd_data), m_rd);
      for (int s = 0; s < NS; s++)
        chk(lt_tag, $sformatf("latest[%0d]", s), int'(latest_flat[s*10 +: 10]), m_latest[s]);
    end
  end

  // Converter model and random host reads.
  int lat = 3, countdown = 0, next_val = 5;
  bit spur_en = 0;
  initial begin
    adc_done = 0; adc_data = '0; rd_sig = '0; rd_back = '0;
    forever begin
      @(negedge clk);
      adc_done = 0;
      if (conv_start) countdown = lat;
      else if (countdown > 0) begin
        countdown--;
        if (countdown == 0) begin
          adc_done = 1;
          adc_data = 10'(next_val);
          next_val = (next_val * 7 + 13) % 1024;
        end
      end else if (spur_en && ($urandom % 4 == 0)) begin
        adc_done = 1;
        adc_data = 10'($urandom % 1024);
      end
      rd_sig  = 3'($urandom % 8);
      rd_back = 6'($urandom % 64);
    end
  end

  task automatic pulse_ctl(bit f, bit c);
    @(negedge clk); freeze_req = f; freeze_clr = c;
    @(negedge clk); freeze_req = 0; freeze_clr = 0;
  endtask

  localparam int ROUND = SLOT * NS;

  initial begin
    freeze_req = 0; freeze_clr = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    cs_tag = "R2"; sel_tag = "R1"; lt_tag = "R4"; rd_tag = "R6";
    repeat (ROUND * 8) @(negedge clk);
    rd_tag = "R5";                         // run rings past their wrap point
    repeat (ROUND * 55) @(negedge clk);
    cs_tag = "R3"; lat = 13;               // converter slower than a slot
    repeat (ROUND * 6) @(negedge clk);
    cs_tag = "R2"; lat = 2; spur_en = 1;   // R4: unsolicited done strobes
    repeat (ROUND * 4) @(negedge clk);
    spur_en = 0;
    rd_tag = "R7"; lt_tag = "R7";
    pulse_ctl(1, 0);
    repeat (ROUND * 8) @(negedge clk);
    rd_tag = "R8";
    pulse_ctl(0, 1);
    repeat (ROUND * 4) @(negedge clk);
    pulse_ctl(1, 1);                       // freeze must win
    repeat (ROUND * 4) @(negedge clk);
    pulse_ctl(0, 1);
    repeat (ROUND * 4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    misses++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule